// File: doc/BRIEF.md
# Packed Unsigned Word Compare Unit

This execution unit handles one 128-bit SIMD instruction: an unsigned greater-than compare over four 32-bit word lanes. A 32-bit instruction word arrives with a valid strobe. The unit decodes it and reads two source vectors from a private 32-entry vector register file. Each lane of the result is all ones when the A lane is strictly greater than the B lane as an unsigned number, and all zeros otherwise. The resulting lane mask is written to the destination register on the next clock edge. When the record flag in the instruction is set, a 4-bit condition field is also updated. It reports whether every lane compared true and whether every lane compared false.

The instruction input is a valid/ready stream. The unit never applies back-pressure, so `inst_ready` is held high: a word is taken on every edge where `inst_valid` is high. Words that do not decode are consumed without effect. A separate load port fills the register file, and a combinational peek port reads any register back. The compare result is also driven combinationally on `res_mask` in the cycle the instruction is presented.

Top module: `vcmp_unit`

## Requirements
- R1: `dec_hit` is high exactly when instruction bits [31:26] equal 4 and bits [9:0] equal 646, whatever the value of the record bit [10]. Register fields are [25:21] destination, [20:16] source A and [15:11] source B.
- R2: Lane i of a vector occupies bits [127-32i : 96-32i], so lane 0 is the most significant word. In the same cycle, `res_mask` lane i is 0xFFFFFFFF when A lane i is greater than B lane i as an unsigned value, and zero otherwise.
- R3: The compare is unsigned: a lane holding 0x80000000 against 0x00000001 gives all ones, and 0xFFFFFFFF against 0xFFFFFFFE gives all ones.
- R4: Equal lanes give a zero lane. This includes lanes where both values are 0 and lanes where both are 0xFFFFFFFF.
- R5: On the edge after `inst_valid` is high with `dec_hit` high, the destination register takes the mask.
- R6: When the destination equals a source register, the mask is computed from the source values as they were before the write.
- R7: When a decoded valid instruction has record bit 1, `cr_field` takes {all lanes true, 0, all lanes false, 0} on the next edge, in bit order [3:0].
- R8: If the record bit is 0, or `dec_hit` is low, or `inst_valid` is low, `cr_field` is unchanged. A word that does not decode, or that is not valid, writes no register.
- R9: Reset clears `cr_field` to 0. `inst_ready` is always high.
- R10: A load writes `ld_data` into register `ld_idx` on the next edge. If an instruction writes the same register in the same cycle, the instruction result is kept.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| inst_valid | input | 1 | Instruction stream valid |
| inst_ready | output | 1 | Instruction stream ready, always high |
| inst_word | input | 32 | Instruction word |
| dec_hit | output | 1 | Instruction decodes as the unsigned word compare |
| res_mask | output | 128 | Lane mask for the presented instruction |
| cr_field | output | 4 | Condition summary {all-true, 0, all-false, 0} |
| ld_valid | input | 1 | Register load strobe |
| ld_idx | input | 5 | Register written by the load |
| ld_data | input | 128 | Load value |
| peek_idx | input | 5 | Register to read back |
| peek_data | output | 128 | Content of register `peek_idx` |

## Verification
The hardest case to reach from the ports is a load and an instruction result landing on the same register in the same cycle. A close second is an instruction whose destination is also one of its sources. For both, the outcome only shows on a later peek. The stimulus forces each case deliberately: it sets the load index equal to the destination field, and it issues self-overwriting compares. It then peeks that register in the following cycle. A long random stream of legal, record-form and malformed words with concurrent loads is compared against the behavioural model on every clock. Before that stream, hand-picked vectors cover boundary lanes.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  localparam int INST_W   = 32;
  localparam int IDX_W    = 5;
  localparam int NREGS    = 1 << IDX_W;
  localparam int PRIM_W   = 6;
  localparam int EXT_W    = 10;
  localparam logic [PRIM_W-1:0] PRIM_VAL = 6'd4;
  localparam logic [EXT_W-1:0]  EXT_VAL  = 10'd646;

  typedef struct packed {
    logic [PRIM_W-1:0] prim;
    logic [IDX_W-1:0]  dst;
    logic [IDX_W-1:0]  srca;
    logic [IDX_W-1:0]  srcb;
    logic              rec;
    logic [EXT_W-1:0]  ext;
  } inst_t;
endpackage

// File: rtl/vcmp_decode.sv
module vcmp_decode
  import vcmp_pkg::*;
(
  input  logic [INST_W-1:0] word,
  output logic              hit,
  output logic [IDX_W-1:0]  dst,
  output logic [IDX_W-1:0]  srca,
  output logic [IDX_W-1:0]  srcb,
  output logic              rec
);
  inst_t f;
  always_comb begin
    f    = inst_t'(word);
    hit  = (f.prim == PRIM_VAL) && (f.ext == EXT_VAL);
    dst  = f.dst;
    srca = f.srca;
    srcb = f.srcb;
    rec  = f.rec;
  end
endmodule

// File: rtl/vcmp_regfile.sv
module vcmp_regfile
  import vcmp_pkg::*;
#(
  parameter int VEC_W = 128
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] ra_idx,
  output logic [VEC_W-1:0] ra_data,
  input  logic [IDX_W-1:0] rb_idx,
  output logic [VEC_W-1:0] rb_data,
  input  logic [IDX_W-1:0] pk_idx,
  output logic [VEC_W-1:0] pk_data,
  input  logic             we,
  input  logic [IDX_W-1:0] w_idx,
  input  logic [VEC_W-1:0] w_data,
  input  logic             ld_en,
  input  logic [IDX_W-1:0] ld_idx,
  input  logic [VEC_W-1:0] ld_data
);
  logic [VEC_W-1:0] mem [NREGS];

  assign ra_data = mem[ra_idx];
  assign rb_data = mem[rb_idx];
  assign pk_data = mem[pk_idx];

  // later assignment wins: instruction result beats a same-index load
  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
    if (we)    mem[w_idx]  <= w_data;
  end

  assert_result_stored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem[$past(w_idx)] == $past(w_data));
  assert_load_stored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && !(we && w_idx == ld_idx)) |=> mem[$past(ld_idx)] == $past(ld_data));
endmodule

// File: rtl/vcmp_lanes.sv
module vcmp_lanes #(
  parameter int LANE_W = 32,
  parameter int LANES  = 4
)(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANE_W*LANES-1:0] a,
  input  logic [LANE_W*LANES-1:0] b,
  output logic [LANE_W*LANES-1:0] mask,
  output logic                    all_true,
  output logic                    all_false
);
  localparam int VEC_W = LANE_W * LANES;
  logic [LANES-1:0] gt;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int HI = VEC_W - 1 - g * LANE_W;
    assign gt[g] = a[HI -: LANE_W] > b[HI -: LANE_W];
    assign mask[HI -: LANE_W] = {LANE_W{gt[g]}};

    assert_equal_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (a[HI -: LANE_W] == b[HI -: LANE_W]) |-> (mask[HI -: LANE_W] == '0));
  end

  assign all_true  = &gt;
  assign all_false = ~|gt;
endmodule

// File: rtl/vcmp_unit.sv
module vcmp_unit
  import vcmp_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int VEC_W = LANE_W * LANES
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inst_valid,
  output logic               inst_ready,
  input  logic [INST_W-1:0]  inst_word,
  output logic               dec_hit,
  output logic [VEC_W-1:0]   res_mask,
  output logic [3:0]         cr_field,
  input  logic               ld_valid,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [VEC_W-1:0]   ld_data,
  input  logic [IDX_W-1:0]   peek_idx,
  output logic [VEC_W-1:0]   peek_data
);
  logic [IDX_W-1:0] dst, srca, srcb;
  logic             rec, fire, all_t, all_f;
  logic [VEC_W-1:0] va, vb;

  assign inst_ready = 1'b1;

  vcmp_decode u_dec (
    .word(inst_word), .hit(dec_hit), .dst(dst), .srca(srca), .srcb(srcb), .rec(rec)
  );

  assign fire = inst_valid && dec_hit;

  vcmp_regfile #(.VEC_W(VEC_W)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(srca), .ra_data(va),
    .rb_idx(srcb), .rb_data(vb),
    .pk_idx(peek_idx), .pk_data(peek_data),
    .we(fire), .w_idx(dst), .w_data(res_mask),
    .ld_en(ld_valid), .ld_idx(ld_idx), .ld_data(ld_data)
  );

  vcmp_lanes #(.LANE_W(LANE_W), .LANES(LANES)) u_lanes (
    .clk(clk), .rst_n(rst_n), .a(va), .b(vb),
    .mask(res_mask), .all_true(all_t), .all_false(all_f)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cr_field <= 4'b0000;
    else if (fire && rec)  cr_field <= {all_t, 1'b0, all_f, 1'b0};
  end

  assert_cr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(inst_valid && dec_hit && rec) |=> $stable(cr_field));
  assert_cr_zero_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && dec_hit && rec) |=> (cr_field[2] == 1'b0 && cr_field[0] == 1'b0));
  assert_cr_alltrue_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inst_valid && dec_hit && rec) |=> (cr_field[3] == (&$past(res_mask))));
  assert_cr_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cr_field[3], cr_field[1]}) <= 1);
endmodule

// File: tb/sim_vcmp_unit.sv
module sim_vcmp_unit;
  localparam int VW = 128;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inst_valid = 1'b0;
  logic inst_ready;
  logic [31:0] inst_word = '0;
  logic dec_hit;
  logic [VW-1:0] res_mask;
  logic [3:0] cr_field;
  logic ld_valid = 1'b0;
  logic [4:0] ld_idx = '0;
  logic [VW-1:0] ld_data = '0;
  logic [4:0] peek_idx = '0;
  logic [VW-1:0] peek_data;

  int checks = 0, fails = 0;
  logic [VW-1:0] mregs [32];
  logic [3:0] mcr = 4'b0;

  always #10 clk = ~clk;

  vcmp_unit u0 (.*);

  function automatic logic [31:0] mk(input int rt, ra, rb, rc, xo, op);
    return {op[5:0], rt[4:0], ra[4:0], rb[4:0], rc[0], xo[9:0]};
  endfunction

  function automatic logic [VW-1:0] lanes4(input logic [31:0] l0, l1, l2, l3);
    return {l0, l1, l2, l3};
  endfunction

  task automatic chk(input string tag, input logic [VW-1:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus plus comparison against the model
  task automatic step(input logic v, input logic [31:0] w, input logic le,
                      input int li, input logic [VW-1:0] ld, input int pk);
    logic hit; logic [VW-1:0] m; int nt;
    @(negedge clk);
    inst_valid = v; inst_word = w; ld_valid = le; ld_idx = li[4:0];
    ld_data = ld; peek_idx = pk[4:0];
    #2;
    hit = (w[31:26] == 6'd4) && (w[9:0] == 10'd646);
    m = '0; nt = 0;
    for (int i = 0; i < 4; i++) begin
      int unsigned a, b;
      a = mregs[w[20:16]][127-32*i -: 32];
      b = mregs[w[15:11]][127-32*i -: 32];
      if (a > b) begin m[127-32*i -: 32] = 32'hFFFFFFFF; nt++; end
    end
    chk("R1 dec_hit", VW'(dec_hit), VW'(hit));
    chk("R2 res_mask", res_mask, m);
    chk("R7 R8 R9 cr_field", VW'(cr_field), VW'(mcr));
    chk("R5 R10 peek", peek_data, mregs[pk]);
    chk("R9 ready", VW'(inst_ready), VW'(1'b1));
    if (le) mregs[li] = ld;
    if (v && hit) begin
      mregs[w[25:21]] = m;
      if (w[10]) mcr = {nt == 4, 1'b0, nt == 0, 1'b0};
    end
  endtask

  localparam int XO = 646;
  logic done = 1'b0;

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset cr", VW'(cr_field), VW'(4'b0));
    rst_n = 1'b1;
    for (int r = 0; r < 32; r++)
      step(0, 0, 1, r, {4{$urandom()}} ^ VW'(r), 0);
    // boundary vectors
    step(0, 0, 1, 1, lanes4(32'h80000000, 32'hFFFFFFFF, 32'h5, 32'h0), 0);
    step(0, 0, 1, 2, lanes4(32'h00000001, 32'hFFFFFFFE, 32'h4, 32'hFFFFFFFF), 1);
    step(0, 0, 1, 3, lanes4(32'h0, 32'hFFFFFFFF, 32'h7, 32'h80000000), 2);
    // R3 mixed unsigned, record: not all true, not all false
    step(1, mk(10, 1, 2, 1, XO, 4), 0, 0, 0, 3);
    step(0, 0, 0, 0, 0, 10);
    // R4 equal lanes: reg3 vs itself, record -> all false
    step(1, mk(11, 3, 3, 1, XO, 4), 0, 0, 0, 10);
    step(0, 0, 0, 0, 0, 11);
    // all true record: reg1 vs reg 4 loaded zero except lane3 compare fails? load zeros with lane3 0 -> reg1 lane3 0, use reg2 vs zeros
    step(0, 0, 1, 4, '0, 0);
    step(1, mk(12, 2, 4, 1, XO, 4), 0, 0, 0, 4);
    step(0, 0, 0, 0, 0, 12);
    // R8 plain form leaves cr
    step(1, mk(13, 4, 2, 0, XO, 4), 0, 0, 0, 12);
    // R8 wrong XO, wrong opcode, invalid strobe: no write
    step(1, mk(14, 2, 4, 1, XO + 1, 4), 0, 0, 0, 13);
    step(1, mk(14, 2, 4, 1, XO, 5), 0, 0, 0, 14);
    step(0, mk(14, 2, 4, 1, XO, 4), 0, 0, 0, 14);
    step(0, 0, 0, 0, 0, 14);
    // R6 aliasing: dest = A
    step(1, mk(2, 2, 4, 0, XO, 4), 0, 0, 0, 2);
    step(0, 0, 0, 0, 0, 2);
    // R10 collision: load and instruction to same register
    step(1, mk(5, 1, 3, 1, XO, 4), 1, 5, {4{32'hA5A5A5A5}}, 5);
    step(0, 0, 0, 0, 0, 5);
    // R10 load alone
    step(0, 0, 1, 6, {4{32'h12345678}}, 6);
    step(0, 0, 0, 0, 0, 6);
    // random stream
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w; int sel;
      sel = $urandom_range(0, 9);
      if (sel < 7)
        w = mk($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
               $urandom_range(0, 1), XO, 4);
      else if (sel == 7)
        w = mk($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31),
               $urandom_range(0, 1), $urandom_range(0, 1023), 4);
      else
        w = $urandom();
      step($urandom_range(0, 3) != 0, w, $urandom_range(0, 3) == 0,
           (sel == 2) ? int'(w[25:21]) : $urandom_range(0, 31),
           {$urandom(), $urandom(), $urandom(), $urandom()}, $urandom_range(0, 31));
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule